// File: doc/BRIEF.md
# Error Exception Restart-Address Register

This block holds the restart address that the processor uses after an error-class exception: cold reset, soft reset or non-maskable interrupt. When such an exception is taken, the register chooses between two addresses. One is the address of the faulting instruction. The other is the address of the instruction just before it, which is a branch, a jump or an extend prefix. The choice depends on the delay-slot and prefix context and on the instruction-set mode, so the stored value never points into a branch delay slot.

When compressed (16-bit) execution is enabled, the least significant bit of the stored value records the mode that was active when the exception occurred. The enable comes from a board strap, which is latched once after reset.

An error-level status bit, supplied from outside, stops all captures while it is set. A later exception therefore cannot overwrite the first saved address. Software can write the register directly and can read it back through a registered port.

Top module: `errpc_capture`

## Requirements
- R1: After reset, `epc_o` and `rd_data_o` are both zero.
- R2: An exception with `exc_valid_i`=1 and `exc_cls_i` equal to 1 (cold reset), 2 (soft reset) or 3 (NMI) updates `epc_o` on the next clock edge. Class 0 (any other exception) never changes `epc_o`.
- R3: With compressed mode latched off, a capture stores `prev_pc_i` when `in_delay_i`=1 and `fault_pc_i` otherwise. Bit 0 is stored as 0, and `isa16_i` and `after_ext_i` are ignored.
- R4: With compressed mode latched on and `isa16_i`=0, a capture stores `prev_pc_i` when `in_delay_i`=1 and `fault_pc_i` otherwise, ignoring `after_ext_i`. Bit 0 is stored as 0.
- R5: With compressed mode latched on and `isa16_i`=1, a capture stores `prev_pc_i` when `in_delay_i`=1 or `after_ext_i`=1, and `fault_pc_i` otherwise. Bit 0 is stored as 1.
- R6: A capture is suppressed when `erl_i`=1 in the same cycle as the exception. Only the level before the exception sets it counts.
- R7: `sw_wr_i`=1 stores the full `sw_wdata_i` in `epc_o` on the next clock edge. This holds whatever the level of `erl_i`.
- R8: When a capture and a software write fall in the same cycle, the capture value is stored.
- R9: `sw_rd_i`=1 loads `rd_data_o` with the value `epc_o` had in that cycle, one clock later. Otherwise `rd_data_o` holds its value.
- R10: `cmode_strap_i` is latched on the first clock edge after reset release. Later changes have no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmode_strap_i | input | 1 | Compressed-mode enable strap |
| exc_valid_i | input | 1 | An exception is taken this cycle |
| exc_cls_i | input | 2 | Exception class: 0 other, 1 cold reset, 2 soft reset, 3 NMI |
| fault_pc_i | input | ADDR_W | Address of the faulting instruction |
| prev_pc_i | input | ADDR_W | Address of the preceding branch, jump or extend prefix |
| in_delay_i | input | 1 | Faulting instruction is in a delay slot |
| after_ext_i | input | 1 | Faulting instruction follows an extend prefix |
| isa16_i | input | 1 | Current mode is 16-bit |
| erl_i | input | 1 | Error-level status bit before this exception |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | ADDR_W | Software write data |
| sw_rd_i | input | 1 | Software read strobe |
| epc_o | output | ADDR_W | Stored restart value |
| rd_data_o | output | ADDR_W | Registered read data |

## Verification
The bench targets the extend-prefix case, which must choose the preceding address only in 16-bit mode with the strap on. A design that honours the prefix in 32-bit mode, or with the strap off, saves the wrong instruction. It also toggles the strap after it has been latched. A design that follows the live pin flips the mode bit on captures made after the toggle.

Error exceptions are raised with the error-level bit set, and some of them coincide with software writes. A design that drops the level gate loses the first saved address. A design that gives the write priority stores the software value instead of the restart address. Finally, the read strobe is exercised next to writes, so that a read path returning the current rather than the registered value shows up one cycle early.

// File: rtl/errpc_pkg.sv
package errpc_pkg;

   typedef enum logic [1:0] {
      EXC_OTHER = 2'd0,
      EXC_COLD  = 2'd1,
      EXC_SOFT  = 2'd2,
      EXC_NMI   = 2'd3
   } exc_cls_e;

   function automatic logic is_error_class(exc_cls_e cls);
      return cls != EXC_OTHER;
   endfunction

endpackage

// File: rtl/errpc_strap_latch.sv
module errpc_strap_latch #(
   parameter bit HAS_CMODE = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strap_i,
   output logic cmode_o,
   output logic locked_o
);

   generate
      if (HAS_CMODE) begin : g_latch
         logic cmode_q;
         logic locked_q;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               cmode_q  <= 1'b0;
               locked_q <= 1'b0;
            end else if (!locked_q) begin
               cmode_q  <= strap_i;
               locked_q <= 1'b1;
            end
         end

         assign cmode_o  = cmode_q;
         assign locked_o = locked_q;
      end else begin : g_none
         logic unused_strap;
         logic unused_clk;
         logic unused_rst;
         assign unused_strap = strap_i;
         assign unused_clk   = clk_i;
         assign unused_rst   = rst_ni;
         assign cmode_o      = 1'b0;
         assign locked_o     = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/errpc_select.sv
module errpc_select #(
   parameter int ADDR_W = 32
) (
   input  logic              cmode_i,
   input  logic              isa16_i,
   input  logic              in_delay_i,
   input  logic              after_ext_i,
   input  logic [ADDR_W-1:0] fault_pc_i,
   input  logic [ADDR_W-1:0] prev_pc_i,
   output logic [ADDR_W-1:0] value_o
);

   localparam int HI = ADDR_W - 1;

   logic mode16;
   logic use_prev;
   logic [HI:1] upper;

   always_comb begin
      mode16   = cmode_i & isa16_i;
      use_prev = in_delay_i | (mode16 & after_ext_i);
      upper    = use_prev ? prev_pc_i[HI:1] : fault_pc_i[HI:1];
      value_o  = {upper, mode16};
   end

   logic unused_lsb;
   assign unused_lsb = fault_pc_i[0] ^ prev_pc_i[0];

endmodule

// File: rtl/errpc_store.sv
module errpc_store #(
   parameter int ADDR_W = 32
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cap_i,
   input  logic [ADDR_W-1:0] cap_val_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] wdata_i,
   input  logic              rd_i,
   output logic [ADDR_W-1:0] epc_o,
   output logic [ADDR_W-1:0] rd_data_o
);

   logic [ADDR_W-1:0] epc_q;
   logic [ADDR_W-1:0] rd_q;
   logic [ADDR_W-1:0] epc_d;

   always_comb begin
      epc_d = epc_q;
      if (cap_i) begin
         epc_d = cap_val_i;
      end else if (wr_i) begin
         epc_d = wdata_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         epc_q <= '0;
         rd_q  <= '0;
      end else begin
         epc_q <= epc_d;
         if (rd_i) begin
            rd_q <= epc_q;
         end
      end
   end

   assign epc_o     = epc_q;
   assign rd_data_o = rd_q;

endmodule

// File: rtl/errpc_capture.sv
module errpc_capture #(
   parameter int ADDR_W    = 32,
   parameter bit HAS_CMODE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cmode_strap_i,
   input  logic              exc_valid_i,
   input  logic [1:0]        exc_cls_i,
   input  logic [ADDR_W-1:0] fault_pc_i,
   input  logic [ADDR_W-1:0] prev_pc_i,
   input  logic              in_delay_i,
   input  logic              after_ext_i,
   input  logic              isa16_i,
   input  logic              erl_i,
   input  logic              sw_wr_i,
   input  logic [ADDR_W-1:0] sw_wdata_i,
   input  logic              sw_rd_i,
   output logic [ADDR_W-1:0] epc_o,
   output logic [ADDR_W-1:0] rd_data_o
);

   import errpc_pkg::*;

   generate
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_width
         $error("errpc_capture: ADDR_W must be within 2..64");
      end
   endgenerate

   logic              cmode_q;
   logic              cmode_locked;
   logic              cap;
   logic [ADDR_W-1:0] cap_val;
   exc_cls_e          cls;

   assign cls = exc_cls_e'(exc_cls_i);
   assign cap = exc_valid_i & is_error_class(cls) & ~erl_i;

   errpc_strap_latch #(
      .HAS_CMODE (HAS_CMODE)
   ) u_strap (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .strap_i  (cmode_strap_i),
      .cmode_o  (cmode_q),
      .locked_o (cmode_locked)
   );

   errpc_select #(
      .ADDR_W (ADDR_W)
   ) u_sel (
      .cmode_i     (cmode_q),
      .isa16_i     (isa16_i),
      .in_delay_i  (in_delay_i),
      .after_ext_i (after_ext_i),
      .fault_pc_i  (fault_pc_i),
      .prev_pc_i   (prev_pc_i),
      .value_o     (cap_val)
   );

   errpc_store #(
      .ADDR_W (ADDR_W)
   ) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cap_i     (cap),
      .cap_val_i (cap_val),
      .wr_i      (sw_wr_i),
      .wdata_i   (sw_wdata_i),
      .rd_i      (sw_rd_i),
      .epc_o     (epc_o),
      .rd_data_o (rd_data_o)
   );

endmodule

// File: rtl/errpc_capture_chk.sv
module errpc_capture_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              exc_valid_i,
   input logic [1:0]        exc_cls_i,
   input logic [ADDR_W-1:0] fault_pc_i,
   input logic [ADDR_W-1:0] prev_pc_i,
   input logic              in_delay_i,
   input logic              isa16_i,
   input logic              erl_i,
   input logic              sw_wr_i,
   input logic [ADDR_W-1:0] sw_wdata_i,
   input logic              sw_rd_i,
   input logic              cmode_q,
   input logic              cmode_locked,
   input logic [ADDR_W-1:0] epc_o,
   input logic [ADDR_W-1:0] rd_data_o
);

   localparam int HI = ADDR_W - 1;

   logic err_take;
   assign err_take = exc_valid_i && (exc_cls_i != 2'd0) && !erl_i;

   // R2: ordinary exceptions leave the register alone
   p_other_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (exc_valid_i && exc_cls_i == 2'd0 && !sw_wr_i) |=> $stable(epc_o));

   // R3 / R4: delay slot always selects the preceding address
   p_delay_prev_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_take && in_delay_i) |=> epc_o[HI:1] == $past(prev_pc_i[HI:1]));

   // R4: 32-bit mode without delay selects the faulting address
   p_fault_32_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_take && !in_delay_i && !isa16_i) |=> epc_o[HI:1] == $past(fault_pc_i[HI:1]));

   // R5: mode bit records 16-bit execution only when enabled
   p_mode_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_take |=> epc_o[0] == ($past(cmode_q) && $past(isa16_i)));

   // R6: error level blocks capture
   p_erl_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (erl_i && !sw_wr_i) |=> $stable(epc_o));

   // R7: plain software write
   p_sw_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sw_wr_i && !err_take) |=> epc_o == $past(sw_wdata_i));

   // R9: registered read latency
   p_read_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sw_rd_i |=> rd_data_o == $past(epc_o));

   p_read_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sw_rd_i |=> $stable(rd_data_o));

   // R10: strap value frozen once latched
   p_strap_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmode_locked |=> ($stable(cmode_q) && cmode_locked));

endmodule

bind errpc_capture errpc_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .exc_valid_i  (exc_valid_i),
   .exc_cls_i    (exc_cls_i),
   .fault_pc_i   (fault_pc_i),
   .prev_pc_i    (prev_pc_i),
   .in_delay_i   (in_delay_i),
   .isa16_i      (isa16_i),
   .erl_i        (erl_i),
   .sw_wr_i      (sw_wr_i),
   .sw_wdata_i   (sw_wdata_i),
   .sw_rd_i      (sw_rd_i),
   .cmode_q      (cmode_q),
   .cmode_locked (cmode_locked),
   .epc_o        (epc_o),
   .rd_data_o    (rd_data_o)
);

// File: tb/errpc_capture_tb_top.sv
`timescale 1ns/1ps
module errpc_capture_tb_top;

   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          strap = 1'b0;
   logic          exc_v = 1'b0;
   logic [1:0]    cls = 2'd0;
   logic [AW-1:0] fpc = '0;
   logic [AW-1:0] ppc = '0;
   logic          dly = 1'b0;
   logic          ext = 1'b0;
   logic          i16 = 1'b0;
   logic          erl = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] wdat = '0;
   logic          rd = 1'b0;
   logic [AW-1:0] epc;
   logic [AW-1:0] rdat;

   int    n_vec = 0;
   int    n_bad = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   errpc_capture #(.ADDR_W(AW)) dut_i (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .cmode_strap_i (strap),
      .exc_valid_i   (exc_v),
      .exc_cls_i     (cls),
      .fault_pc_i    (fpc),
      .prev_pc_i     (ppc),
      .in_delay_i    (dly),
      .after_ext_i   (ext),
      .isa16_i       (i16),
      .erl_i         (erl),
      .sw_wr_i       (wr),
      .sw_wdata_i    (wdat),
      .sw_rd_i       (rd),
      .epc_o         (epc),
      .rd_data_o     (rdat)
   );

   // behavioural reference model
   logic [AW-1:0] m_epc, m_rd;
   bit            m_locked, m_cm;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_epc    <= '0;
         m_rd     <= '0;
         m_locked <= 1'b0;
         m_cm     <= 1'b0;
      end else begin
         bit            take, from_prev, sixteen;
         logic [AW-1:0] src;
         if (!m_locked) begin
            m_locked <= 1'b1;
            m_cm     <= strap;
         end
         take      = exc_v && (cls != 2'd0) && !erl;
         sixteen   = m_cm && i16;
         from_prev = dly || (sixteen && ext);
         src       = from_prev ? ppc : fpc;
         if (take)    m_epc <= (src & ~32'd1) | {31'd0, sixteen};
         else if (wr) m_epc <= wdat;
         if (rd)      m_rd  <= m_epc;
      end
   end

   task automatic compare();
      n_vec++;
      if (epc !== m_epc) begin
         n_bad++;
         $display("FAIL %s epc_o actual=%h expected=%h", cur_req, epc, m_epc);
      end
      n_vec++;
      if (rdat !== m_rd) begin
         n_bad++;
         $display("FAIL %s rd_data_o actual=%h expected=%h", cur_req, rdat, m_rd);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      compare();
      exc_v = 0; cls = 0; dly = 0; ext = 0; i16 = 0; erl = 0;
      wr = 0; rd = 0;
   endtask

   task automatic take_exc(input logic [1:0] c, input logic [AW-1:0] f,
                           input logic [AW-1:0] p, input bit d, input bit e,
                           input bit m16, input bit lvl);
      exc_v = 1; cls = c; fpc = f; ppc = p; dly = d; ext = e; i16 = m16; erl = lvl;
      tick();
   endtask

   task automatic sw_write(input logic [AW-1:0] d);
      wr = 1; wdat = d;
      tick();
   endtask

   task automatic sw_read();
      rd = 1;
      tick();
   endtask

   task automatic do_reset(input bit s);
      @(negedge clk);
      rst_n = 0; strap = s;
      repeat (2) @(negedge clk);
      rst_n = 1;
      cur_req = "R1";
      compare();
   endtask

   initial begin
      #(4 * 20000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, compressed mode off
      do_reset(1'b0);
      sw_read();
      tick();

      // R2: each error class captures, ordinary class does not
      cur_req = "R2";
      take_exc(2'd1, 32'h0000_1000, 32'h0000_0ffc, 0, 0, 0, 0);
      take_exc(2'd0, 32'h0000_2000, 32'h0000_1ffc, 0, 0, 0, 0);
      take_exc(2'd2, 32'h0000_3000, 32'h0000_2ffc, 0, 0, 0, 0);
      take_exc(2'd3, 32'h0000_4000, 32'h0000_3ffc, 0, 0, 0, 0);

      // R3: compressed mode off
      cur_req = "R3";
      take_exc(2'd3, 32'h0000_5004, 32'h0000_5000, 1, 0, 0, 0);
      take_exc(2'd3, 32'h0000_6003, 32'h0000_6001, 0, 1, 1, 0);
      take_exc(2'd1, 32'h0000_7005, 32'h0000_7001, 1, 1, 1, 0);

      // R6: error level blocks capture
      cur_req = "R6";
      take_exc(2'd3, 32'hdead_0000, 32'hdead_0004, 0, 0, 0, 1);
      take_exc(2'd2, 32'hbeef_0000, 32'hbeef_0004, 1, 0, 0, 1);

      // R7: software write, also under error level
      cur_req = "R7";
      sw_write(32'h1234_5679);
      erl = 1; sw_write(32'hcafe_f00d);

      // R9: read latency and hold
      cur_req = "R9";
      sw_read();
      sw_write(32'h0bad_0001);
      tick();
      sw_read();
      tick();

      // R8: capture beats write
      cur_req = "R8";
      wr = 1; wdat = 32'hffff_ffff;
      take_exc(2'd1, 32'h0000_8000, 32'h0000_7ffc, 0, 0, 0, 0);

      // R10: strap toggled after latch is ignored
      cur_req = "R10";
      strap = 1;
      take_exc(2'd3, 32'h0000_9002, 32'h0000_9000, 0, 1, 1, 0);
      sw_read();

      // reset with strap on
      do_reset(1'b1);
      cur_req = "R10";
      tick();
      strap = 0;
      take_exc(2'd3, 32'h0000_a002, 32'h0000_a000, 0, 0, 1, 0);

      // R4: 32-bit mode with compressed enabled
      cur_req = "R4";
      take_exc(2'd2, 32'h0000_b004, 32'h0000_b000, 0, 1, 0, 0);
      take_exc(2'd2, 32'h0000_c004, 32'h0000_c000, 1, 0, 0, 0);

      // R5: 16-bit mode selection and mode bit
      cur_req = "R5";
      take_exc(2'd1, 32'h0000_d004, 32'h0000_d000, 0, 1, 1, 0);
      take_exc(2'd1, 32'h0000_e002, 32'h0000_e000, 1, 0, 1, 0);
      take_exc(2'd3, 32'h0000_f002, 32'h0000_f000, 0, 0, 1, 0);
      sw_read();

      // R8 again in 16-bit mode
      cur_req = "R8";
      wr = 1; wdat = 32'h5555_5554;
      take_exc(2'd2, 32'h0001_0002, 32'h0001_0000, 0, 1, 1, 0);

      // mixed patterns
      cur_req = "R2";
      for (int k = 0; k < 300; k++) begin
         exc_v = $urandom_range(0, 1);
         cls   = 2'($urandom_range(0, 3));
         fpc   = $urandom;
         ppc   = $urandom;
         dly   = $urandom_range(0, 1);
         ext   = $urandom_range(0, 1);
         i16   = $urandom_range(0, 1);
         erl   = ($urandom_range(0, 3) == 0);
         wr    = $urandom_range(0, 1);
         wdat  = $urandom;
         rd    = $urandom_range(0, 1);
         tick();
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule